// File: doc/BRIEF.md
# Credit-Based Transmit Flow Gate

This block sits on the sending side of a packet link. It decides, cycle by cycle, whether the packet at the head of the transmit queue may go out. The decision rests on credits that the far-end receiver grants. The receiver first advertises how much buffer space it has, and that amount becomes the allowance. Every packet that leaves adds its credit cost to a usage counter. When the receiver frees buffer space, it sends back credit updates, and each update raises the allowance by the returned amount.

Usage and allowance are free-running counters that wrap. The admit test therefore compares them in modular form, so it stays correct after either counter has passed its top value. If the advertised amount is zero, the link is treated as having unlimited credit, and every packet is admitted. The ready output is a combinational function of the current counters and the head packet's cost. A slow credit return therefore never stalls traffic while credit remains.

Top module: `credit_tx_gate`

## Requirements
- R1: After reset, and until the first initialisation, `pkt_ready` is low for every cost.
- R2: A cycle with `init_valid` high loads `init_credits` as the allowance and clears usage. A later initialisation replaces all earlier state in the same way.
- R3: In metered mode, `pkt_ready` is high exactly when (allowance − ((usage + `pkt_cost`) mod 256)) mod 256 is at most 128. The output reflects `pkt_cost` in the same cycle.
- R4: On a cycle where `pkt_valid` and `pkt_ready` are both high, usage grows by `pkt_cost` modulo 256. On any other cycle, usage is unchanged.
- R5: A cycle with `upd_valid` high raises the allowance by `upd_credits` modulo 256.
- R6: A packet acceptance and a credit update in the same cycle are both applied.
- R7: An initialisation with `init_credits` equal to 0 selects unlimited mode. In that mode `pkt_ready` is high for every cost, and neither accepted packets nor updates ever lower it.
- R8: Usage and allowance wrap past 255, and the admit decision follows R3 across the wrap.
- R9: While `init_valid` is high, `pkt_ready` is low, and a credit update presented in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Head packet present |
| pkt_cost | input | CNT_W | Credit cost of the head packet |
| pkt_ready | output | 1 | Head packet may be sent this cycle |
| init_valid | input | 1 | Load the advertised credit amount |
| init_credits | input | CNT_W | Advertised amount; 0 means unlimited |
| upd_valid | input | 1 | Credit return present |
| upd_credits | input | CNT_W | Amount of credit returned |

## Verification
The assertions assume that every input is a defined value once reset is released. They also assume that the receiver never returns more credit in total than it has taken, so the gap between allowance and usage stays within half the counter range. The stimulus stays inside that assumption: every update and every accepted cost in the wrap test is kept small against the allowance, and unlimited mode is only entered through a zero advertisement. The bench watches `pkt_ready` for chosen costs, and that is how it observes usage and allowance from outside the block.

// File: rtl/credit_gate_pkg.sv
package credit_gate_pkg;
    typedef enum logic [1:0] {
        GATE_IDLE    = 2'd0,
        GATE_METERED = 2'd1,
        GATE_OPEN    = 2'd2
    } gate_mode_e;
endpackage

// File: rtl/mod_adder.sv
module mod_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    // sum wraps modulo 2**W by truncation
    assign sum = a + b;
endmodule

// File: rtl/credit_admit.sv
module credit_admit #(
    parameter int W = 8
) (
    input  logic [W-1:0] limit,
    input  logic [W-1:0] used_after,
    output logic         fits
);
    localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};
    logic [W-1:0] headroom;

    // remaining credit after the packet, read in a half-range window
    assign headroom = limit - used_after;
    assign fits     = (headroom <= HALF);
endmodule

// File: rtl/credit_tx_gate.sv
module credit_tx_gate
    import credit_gate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [CNT_W-1:0] pkt_cost,
    output logic             pkt_ready,
    input  logic             init_valid,
    input  logic [CNT_W-1:0] init_credits,
    input  logic             upd_valid,
    input  logic [CNT_W-1:0] upd_credits
);
    typedef struct packed {
        gate_mode_e       mode;
        logic [CNT_W-1:0] used;
        logic [CNT_W-1:0] limit;
    } gate_state_t;

    gate_state_t st_d, st_q;

    logic [CNT_W-1:0] used_after;
    logic [CNT_W-1:0] limit_raised;
    logic             fits;
    logic             accept;

    mod_adder #(.W(CNT_W)) u_used_add (
        .a  (st_q.used),
        .b  (pkt_cost),
        .sum(used_after)
    );

    mod_adder #(.W(CNT_W)) u_limit_add (
        .a  (st_q.limit),
        .b  (upd_credits),
        .sum(limit_raised)
    );

    credit_admit #(.W(CNT_W)) u_admit (
        .limit     (st_q.limit),
        .used_after(used_after),
        .fits      (fits)
    );

    assign pkt_ready = !init_valid &&
                       ((st_q.mode == GATE_OPEN) ||
                        ((st_q.mode == GATE_METERED) && fits));
    assign accept = pkt_valid && pkt_ready;

    always_comb begin
        st_d = st_q;
        if (init_valid) begin
            st_d.mode  = (init_credits == '0) ? GATE_OPEN : GATE_METERED;
            st_d.used  = '0;
            st_d.limit = init_credits;
        end else begin
            if (accept) begin
                st_d.used = used_after;
            end
            if (upd_valid) begin
                st_d.limit = limit_raised;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode  <= GATE_IDLE;
            st_q.used  <= '0;
            st_q.limit <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/credit_tx_gate_chk.sv
module credit_tx_gate_chk
    import credit_gate_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pkt_valid,
    input logic [CNT_W-1:0] pkt_cost,
    input logic             pkt_ready,
    input logic             init_valid,
    input logic [CNT_W-1:0] init_credits,
    input logic             upd_valid,
    input logic [CNT_W-1:0] upd_credits,
    input gate_mode_e       mode,
    input logic [CNT_W-1:0] used,
    input logic [CNT_W-1:0] limit
);
    AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == GATE_IDLE) |-> !pkt_ready); // R1

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |=> (limit == $past(init_credits)) && (used == '0)); // R2

    AST_INIT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        init_valid |-> !pkt_ready); // R9

    AST_USED_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> used == CNT_W'($past(used) + $past(pkt_cost))); // R4

    AST_USED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(pkt_valid && pkt_ready) && !init_valid) |=> $stable(used)); // R4

    AST_LIMIT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !init_valid) |=> limit == CNT_W'($past(limit) + $past(upd_credits))); // R5

    AST_OPEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == GATE_OPEN) && !init_valid) |-> pkt_ready); // R7
endmodule

bind credit_tx_gate credit_tx_gate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pkt_valid   (pkt_valid),
    .pkt_cost    (pkt_cost),
    .pkt_ready   (pkt_ready),
    .init_valid  (init_valid),
    .init_credits(init_credits),
    .upd_valid   (upd_valid),
    .upd_credits (upd_credits),
    .mode        (st_q.mode),
    .used        (st_q.used),
    .limit       (st_q.limit)
);

// File: tb/sim_credit_tx_gate.sv
`timescale 1ns/1ps
module sim_credit_tx_gate;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pkt_valid = 1'b0;
    logic [CNT_W-1:0] pkt_cost = '0;
    logic             pkt_ready;
    logic             init_valid = 1'b0;
    logic [CNT_W-1:0] init_credits = '0;
    logic             upd_valid = 1'b0;
    logic [CNT_W-1:0] upd_credits = '0;

    always #4 clk = ~clk;

    credit_tx_gate #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .pkt_valid(pkt_valid), .pkt_cost(pkt_cost), .pkt_ready(pkt_ready),
        .init_valid(init_valid), .init_credits(init_credits),
        .upd_valid(upd_valid), .upd_credits(upd_credits)
    );

    typedef struct {
        logic  exp;
        string req;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference state: 0 idle, 1 metered, 2 unlimited
    int m_mode = 0;
    int m_lim = 0;
    int m_used = 0;

    task automatic cyc(input logic v, input int cost, input logic iv, input int ic,
                       input logic uv, input int uc, input string req);
        exp_t e;
        int head;
        @(posedge clk);
        #1;
        pkt_valid = v; pkt_cost = CNT_W'(cost);
        init_valid = iv; init_credits = CNT_W'(ic);
        upd_valid = uv; upd_credits = CNT_W'(uc);
        head = (m_lim - ((m_used + cost) % 256) + 512) % 256;
        e.exp = !iv && (m_mode == 2 || (m_mode == 1 && head <= 128));
        e.req = req;
        q.push_back(e);
        if (!rst_n) begin
            m_mode = 0; m_lim = 0; m_used = 0;
        end else if (iv) begin
            m_mode = (ic == 0) ? 2 : 1; m_lim = ic; m_used = 0;
        end else begin
            if (v && e.exp) m_used = (m_used + cost) % 256;
            if (uv) m_lim = (m_lim + uc) % 256;
        end
    endtask

    task automatic probe(input int cost, input string req);
        cyc(1'b0, cost, 1'b0, 0, 1'b0, 0, req);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (pkt_ready !== e.exp) begin
                bad++;
                $display("FAIL %s: pkt_ready=%0b expected=%0b", e.req, pkt_ready, e.exp);
            end
        end
    end

    initial begin
        // R1: reset and the time before initialisation
        cyc(1'b1, 0, 1'b0, 0, 1'b0, 0, "R1 in reset");
        cyc(1'b1, 1, 1'b0, 0, 1'b0, 0, "R1 in reset");
        @(posedge clk); #1 rst_n = 1'b1;
        probe(0, "R1 before init");
        cyc(1'b1, 5, 1'b0, 0, 1'b1, 9, "R1 update before init");
        probe(0, "R1 still idle");

        // R9: init cycle blocks the packet and drops an update
        cyc(1'b1, 1, 1'b1, 10, 1'b1, 50, "R9 init cycle");
        // R2/R3: allowance 10
        probe(10, "R3 exact fit");
        probe(11, "R3 one over");
        probe(137, "R3 far over");
        probe(138, "R3 half-range edge");
        // R4: consume 3+3+3, then 3 is refused
        cyc(1'b1, 3, 1'b0, 0, 1'b0, 0, "R4 send");
        cyc(1'b1, 3, 1'b0, 0, 1'b0, 0, "R4 send");
        cyc(1'b1, 3, 1'b0, 0, 1'b0, 0, "R4 send");
        cyc(1'b1, 3, 1'b0, 0, 1'b0, 0, "R4 refused");
        probe(1, "R4 last credit");
        cyc(1'b1, 1, 1'b0, 0, 1'b0, 0, "R4 send last");
        probe(1, "R4 exhausted");
        // R5: return 5
        cyc(1'b0, 0, 1'b0, 0, 1'b1, 5, "R5 update");
        probe(5, "R5 raised fit");
        probe(6, "R5 raised over");
        // R6: send 4 with update 2 together
        cyc(1'b1, 4, 1'b0, 0, 1'b1, 2, "R6 both");
        probe(3, "R6 both applied");
        probe(4, "R6 both applied over");

        // R2: reinit, R8: wrap
        cyc(1'b0, 0, 1'b1, 100, 1'b0, 0, "R2 reinit");
        probe(100, "R2 new fit");
        probe(101, "R2 new over");
        for (int i = 0; i < 60; i++) begin
            cyc(1'b1, 7, 1'b0, 0, 1'b1, 7, "R8 wrap step");
        end
        probe(100, "R8 after wrap fit");
        probe(101, "R8 after wrap over");
        for (int i = 0; i < 14; i++) begin
            cyc(1'b1, 7, 1'b0, 0, 1'b0, 0, "R8 drain");
        end
        probe(2, "R8 residue");
        probe(3, "R8 residue over");

        // R7: unlimited
        cyc(1'b0, 0, 1'b1, 0, 1'b0, 0, "R7 init zero");
        probe(255, "R7 any cost");
        for (int i = 0; i < 5; i++) begin
            cyc(1'b1, 200, 1'b0, 0, 1'b0, 0, "R7 send");
        end
        cyc(1'b1, 129, 1'b0, 0, 1'b1, 77, "R7 with update");
        probe(128, "R7 still open");

        @(negedge clk); #1;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule